// File: doc/BRIEF.md
# DMA Transfer Counter with Reload

This block keeps the byte count for the DMA engine of a disk-bus controller. Software programs a count, one byte at a time, into a shadow register that the live counter does not see. When a command with the DMA flag (bit 7) is issued, the shadow value is copied into the live counter. A DMA transfer-information command (command code 0x10 with bit 7 set) then starts a transfer. Its length is the live count, with a count of zero read as 65536, clipped to the remaining bus-phase length or to 32 bytes while a command is still being collected.

While the transfer runs, every moved byte decrements both the live counter and the remaining transfer length. When the last byte is accepted, the block raises the terminal-count status bit and loads the bus-service cause (0x10) into the interrupt cause register. It zeroes the live counter, raises the interrupt line, and pulses a done strobe. A neighbouring block uses that strobe to clear its sequence step and FIFO flags. Memory access itself is not handled here.

Top module: `dmac_xfer_count`

## Requirements
- R1: After reset, count_o, remain_o, intr_o are zero and busy_o, tc_o, irq_o, done_o are low.
- R2: A write with wr_addr_i=0 loads bits 7:0 and wr_addr_i=1 loads bits 15:8 of the shadow count; a write alone never changes count_o.
- R3: A write to either shadow byte clears tc_o on the next edge, unless a completion happens on that same edge.
- R4: A command with cmd_i[7]=1 copies the shadow count into count_o; a command with cmd_i[7]=0 leaves count_o unchanged.
- R5: A command 0x90 starts a transfer of length min(C, L), where C is the freshly reloaded count with 0 read as 65536, and L is 32 when collect_i=1 and phase_len_i otherwise; command 0x10 (bit 7 clear) starts nothing.
- R6: Starting a transfer clears tc_o, sets busy_o and loads remain_o with the length.
- R7: Each byte_i strobe during a transfer, in a cycle without a DMA command, decrements count_o (wrapping 0 to 0xFFFF) and remain_o by one.
- R8: The edge that accepts the last byte ends the transfer: busy_o low, tc_o high, intr_o=0x10, count_o=0, irq_o high, and done_o high for exactly one cycle. irq_o then stays high until reset.
- R9: A transfer whose computed length is zero completes on the edge of its start command.
- R10: byte_i strobes while no transfer is active have no effect on count_o or remain_o.
- R11: A DMA command during a transfer reloads count_o and drops a byte strobe in the same cycle. A DMA 0x10 command restarts the transfer with the new length, while another DMA command leaves remain_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Shadow count byte write strobe |
| wr_addr_i | input | 1 | Byte select: 0 low, 1 middle |
| wr_data_i | input | 8 | Write data |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command: bit 7 DMA flag, bits 6:0 code |
| collect_i | input | 1 | Command bytes still being collected (caps length at 32) |
| phase_len_i | input | 17 | Magnitude of the remaining bus-phase length |
| byte_i | input | 1 | One byte moved by the DMA engine |
| count_o | output | 16 | Live transfer counter |
| remain_o | output | 17 | Bytes left in the current transfer |
| busy_o | output | 1 | Transfer active |
| tc_o | output | 1 | Terminal count status bit |
| intr_o | output | 8 | Interrupt cause register |
| irq_o | output | 1 | Interrupt line |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that byte_i is only meaningful while busy_o is high. They also assume that cmd_i carries a defined value whenever cmd_valid_i is high, and that phase_len_i never exceeds 17 bits of magnitude. The stimulus drives each strobe for whole cycles, keeps cmd_i stable while cmd_valid_i is high, and sends idle byte strobes only to check that they are ignored. Completion checks consider only the last accepted byte and zero-length starts. Same-edge collisions between a write and a completion are not driven.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef struct packed {
    logic       dma;
    logic [6:0] code;
  } cmd_t;

  localparam logic [6:0] OP_XFER_INFO = 7'h10;
  localparam logic [7:0] CAUSE_BUS_SVC = 8'h10;
endpackage

// File: rtl/dmac_shadow.sv
module dmac_shadow #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int AW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  shadow_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 lane_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))     lane_q <= wr_data_i;
    end
    assign shadow_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/dmac_len_calc.sv
module dmac_len_calc #(
  parameter int CNT_W = 16,
  parameter int CAP   = 32,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [LEN_W-1:0] limit_i,
  input  logic             collect_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] full, lim;
  always_comb begin
    full  = (count_i == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, count_i};
    lim   = collect_i ? LEN_W'(CAP) : limit_i;
    len_o = (full < lim) ? full : lim;
  end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             start_i,
  input  logic             tc_clr_i,
  input  logic             byte_i,
  input  logic [CNT_W-1:0] shadow_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] count_o,
  output logic [LEN_W-1:0] remain_o,
  output logic             busy_o,
  output logic             tc_o,
  output logic [7:0]       intr_o,
  output logic             irq_o,
  output logic             done_o
);
  logic [CNT_W-1:0] count_q;
  logic [LEN_W-1:0] remain_q;
  logic             tc_q, irq_q, done_q;
  logic [7:0]       cause_q;
  logic             busy, byte_ok, done_now;

  assign busy     = (remain_q != '0);
  // a DMA command owns the cycle: same-cycle byte strobes are dropped
  assign byte_ok  = byte_i && busy && !reload_i;
  assign done_now = start_i ? (len_i == '0)
                            : (byte_ok && remain_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      remain_q <= '0;
      tc_q     <= 1'b0;
      cause_q  <= '0;
      irq_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_now;
      if (done_now) begin
        count_q  <= '0;
        remain_q <= '0;
        tc_q     <= 1'b1;
        cause_q  <= CAUSE_BUS_SVC;
        irq_q    <= 1'b1;
      end else begin
        if (start_i)      remain_q <= len_i;
        else if (byte_ok) remain_q <= remain_q - LEN_W'(1);
        if (reload_i)     count_q  <= shadow_i;
        else if (byte_ok) count_q  <= count_q - CNT_W'(1);
        if (start_i || tc_clr_i) tc_q <= 1'b0;
      end
    end
  end

  assign count_o  = count_q;
  assign remain_o = remain_q;
  assign busy_o   = busy;
  assign tc_o     = tc_q;
  assign intr_o   = cause_q;
  assign irq_o    = irq_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dmac_xfer_count.sv
module dmac_xfer_count
  import dmac_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CAP    = 32,
  localparam int LEN_W = CNT_W + 1,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int AW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_i,
  input  logic              collect_i,
  input  logic [LEN_W-1:0]  phase_len_i,
  input  logic              byte_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic              busy_o,
  output logic              tc_o,
  output logic [7:0]        intr_o,
  output logic              irq_o,
  output logic              done_o
);
  cmd_t             cmd;
  logic             dma_cmd, xfer_cmd;
  logic [CNT_W-1:0] shadow, cnt_eff;
  logic [LEN_W-1:0] len;

  assign cmd      = cmd_t'(cmd_i);
  assign dma_cmd  = cmd_valid_i && cmd.dma;
  assign xfer_cmd = dma_cmd && (cmd.code == OP_XFER_INFO);

  dmac_shadow #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_shadow (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .shadow_o(shadow)
  );

  // the length sees the value being reloaded on this same command
  assign cnt_eff = dma_cmd ? shadow : count_o;

  dmac_len_calc #(.CNT_W(CNT_W), .CAP(CAP)) u_len (
    .count_i(cnt_eff), .limit_i(phase_len_i), .collect_i, .len_o(len)
  );

  dmac_engine #(.CNT_W(CNT_W)) u_eng (
    .clk_i, .rst_ni,
    .reload_i (dma_cmd),
    .start_i  (xfer_cmd),
    .tc_clr_i (wr_en_i),
    .byte_i,
    .shadow_i (shadow),
    .len_i    (len),
    .count_o, .remain_o, .busy_o, .tc_o, .intr_o, .irq_o, .done_o
  );
endmodule

// File: rtl/dmac_xfer_count_chk.sv
module dmac_xfer_count_chk #(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_i,
  input logic             byte_i,
  input logic [CNT_W-1:0] count_o,
  input logic [LEN_W-1:0] remain_o,
  input logic             busy_o,
  input logic             tc_o,
  input logic [7:0]       intr_o,
  input logic             irq_o,
  input logic             done_o
);
  // R3
  wr_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!tc_o || done_o));
  // R4
  nodma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_i[7] && !busy_o) |=> $stable(count_o));
  // R6
  remain_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_o <= (LEN_W'(1) << CNT_W));
  // R7
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_i && !(cmd_valid_i && cmd_i[7]) && remain_o > LEN_W'(1))
    |=> (count_o == $past(count_o) - CNT_W'(1)) && (remain_o == $past(remain_o) - LEN_W'(1)));
  // R8
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tc_o && irq_o && !busy_o && count_o == '0 && intr_o == 8'h10));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cmd_valid_i) |=> !done_o);
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);
  // R8
  tc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> done_o);
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && byte_i && !cmd_valid_i) |=> ($stable(count_o) && !busy_o));
endmodule

bind dmac_xfer_count dmac_xfer_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .cmd_valid_i(cmd_valid_i),
  .cmd_i(cmd_i), .byte_i(byte_i), .count_o(count_o), .remain_o(remain_o),
  .busy_o(busy_o), .tc_o(tc_o), .intr_o(intr_o), .irq_o(irq_o), .done_o(done_o)
);

// File: tb/sim_dmac_xfer_count.sv
module sim_dmac_xfer_count;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic        collect_i = 1'b0;
  logic [16:0] phase_len_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] count_o;
  logic [16:0] remain_o;
  logic        busy_o, tc_o, irq_o, done_o;
  logic [7:0]  intr_o;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;

  always #2 clk_i = ~clk_i;

  dmac_xfer_count u0 (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=50000 cycles", wd);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tick(); tick();
    rst_ni = 1'b1; tick();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; tick(); wr_en_i = 1'b0;
  endtask

  task automatic command(logic [7:0] c, logic with_byte);
    cmd_valid_i = 1'b1; cmd_i = c; byte_i = with_byte; tick();
    cmd_valid_i = 1'b0; byte_i = 1'b0;
  endtask

  task automatic bytes(int n);
    byte_i = 1'b1;
    for (int i = 0; i < n; i++) tick();
    byte_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", 32'(count_o), 0);
    check("R1 remain", 32'(remain_o), 0);
    check("R1 flags", {busy_o, tc_o, irq_o, done_o}, 0);
    check("R1 intr", 32'(intr_o), 0);
  endtask

  task automatic t_reload();
    do_reset();
    wr(1'b0, 8'h05); wr(1'b1, 8'h00);
    check("R2 write no count", 32'(count_o), 0);
    command(8'h80, 1'b0);
    check("R4 reload", 32'(count_o), 32'h5);
    wr(1'b0, 8'h34); wr(1'b1, 8'h12);
    command(8'h00, 1'b0);
    check("R4 no dma keeps count", 32'(count_o), 32'h5);
    command(8'h80, 1'b0);
    check("R2 byte lanes", 32'(count_o), 32'h1234);
    command(8'h10, 1'b0);
    check("R5 no dma no xfer", 32'(busy_o), 0);
  endtask

  task automatic t_basic();
    do_reset();
    wr(1'b0, 8'd5); phase_len_i = 17'd3;
    command(8'h90, 1'b0);
    check("R5 count", 32'(count_o), 5);
    check("R6 remain", 32'(remain_o), 3);
    check("R6 busy/tc", {busy_o, tc_o}, 2'b10);
    bytes(2);
    check("R7 count", 32'(count_o), 3);
    check("R7 remain", 32'(remain_o), 1);
    bytes(1);
    check("R8 count", 32'(count_o), 0);
    check("R8 state", {busy_o, tc_o, irq_o, done_o}, 4'b0111);
    check("R8 intr", 32'(intr_o), 32'h10);
    tick();
    check("R8 done pulse", 32'(done_o), 0);
    check("R8 irq sticky", 32'(irq_o), 1);
    bytes(2);
    check("R10 idle count", 32'(count_o), 0);
    check("R10 idle remain", 32'(remain_o), 0);
    wr(1'b1, 8'h00);
    check("R3 tc clear", 32'(tc_o), 0);
  endtask

  task automatic t_lengths();
    do_reset();
    phase_len_i = 17'd70000;
    command(8'h90, 1'b0);
    check("R5 zero=65536", 32'(remain_o), 32'h10000);
    bytes(1);
    check("R7 wrap", 32'(count_o), 32'hFFFF);
    check("R7 wrap remain", 32'(remain_o), 32'hFFFF);
    do_reset();
    wr(1'b0, 8'd100); collect_i = 1'b1; phase_len_i = 17'd500;
    command(8'h90, 1'b0);
    check("R5 cap 32", 32'(remain_o), 32);
    wr(1'b0, 8'd10);
    command(8'h90, 1'b0);
    check("R5 below cap", 32'(remain_o), 10);
    collect_i = 1'b0;
  endtask

  task automatic t_zero();
    do_reset();
    wr(1'b0, 8'd7); phase_len_i = 17'd0;
    command(8'h90, 1'b0);
    check("R9 zero len", {busy_o, tc_o, irq_o, done_o}, 4'b0111);
    check("R9 count", 32'(count_o), 0);
  endtask

  task automatic t_restart();
    do_reset();
    wr(1'b0, 8'd20); phase_len_i = 17'd100;
    command(8'h90, 1'b0);
    check("R5 len 20", 32'(remain_o), 20);
    bytes(3);
    check("R7 mid", 32'(count_o), 17);
    wr(1'b0, 8'd9);
    command(8'h90, 1'b1);
    check("R11 restart count", 32'(count_o), 9);
    check("R11 restart remain", 32'(remain_o), 9);
    wr(1'b0, 8'd50);
    command(8'h80, 1'b1);
    check("R11 reload count", 32'(count_o), 50);
    check("R11 remain kept", 32'(remain_o), 9);
    bytes(8);
    check("R7 after reload", 32'(count_o), 42);
    check("R7 busy", 32'(busy_o), 1);
    bytes(1);
    check("R8 restart done", {busy_o, tc_o, done_o}, 3'b011);
  endtask

  initial begin
    tick();
    t_reset();
    t_reload();
    t_basic();
    t_lengths();
    t_zero();
    t_restart();
    summary();
    $finish;
  end
endmodule